// File: doc/BRIEF.md
# Four-Drive Floppy Control Switches

This block holds the control side of a floppy disc controller that serves four drives from one card. The card answers to two peripheral-slot device-select strobes: a primary one and an auxiliary one borrowed from a neighbouring slot. Every bus access through either strobe does three things. It writes one bit of a small addressable soft-switch latch, taking the position and the value from the low address bits. It records which strobe was used, and that choice picks the drive pair. It restarts a retriggerable motor timer.

The latch outputs drive the four stepper-phase lines directly, choose the first or second drive inside the current pair, and set the two mode bits (shift/load and read/write) used by a separate serial data path. The pair bit and the in-pair drive bit are decoded into four active-low drive enables. These enables are gated by the motor timer, which keeps running for a parameterised number of clock cycles after the last access. At 1 MHz the default of 1,000,000 cycles is about one second, so the motor does not flicker between byte transfers and runs on briefly after a transfer ends.

Top module: `quad_drive_ctl`

## Requirements
- R1: A clock cycle in which `sel_main_n` is low, or `sel_aux_n` is low, or both are low, is an access. The card treats the two strobes alike for latch writes and for the motor timer.
- R2: On an access, latch output number `addr[3:1]` takes the value `addr[0]` at the clock edge. The other latch outputs keep their values.
- R3: Latch outputs 0 to 3 appear on `step_phase[0]` to `step_phase[3]` in the cycle after the writing edge.
- R4: Latch output 5 selects the drive within the current pair: 0 selects the first drive and 1 selects the second.
- R5: Latch output 6 drives `load_sel` and latch output 7 drives `write_sel`.
- R6: An access with `sel_aux_n` low selects the upper pair. This holds even when `sel_main_n` is also low. An access with only `sel_main_n` low selects the lower pair.
- R7: While the motor runs, exactly one enable is low: `drv_en_n[{pair, latch5}]`, where pair is 0 for the lower pair and 1 for the upper pair. All other enables are high.
- R8: After the edge of the last access, `motor_on` stays high for exactly `MOTOR_HOLD` cycles and then goes low. Each new access restarts the full count.
- R9: While `motor_on` is low, all four `drv_en_n` are high.
- R10: Synchronous active-low reset clears all latch outputs and the pair bit and stops the motor. After reset all phases and mode bits are 0 and all enables are high.
- R11: In a cycle with both strobes high, the address is ignored. No phase, mode bit or pair choice changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_main_n | input | 1 | Primary slot device-select strobe, active low |
| sel_aux_n | input | 1 | Auxiliary slot device-select strobe, active low |
| addr | input | 4 | Low address bits: [3:1] latch position, [0] value |
| step_phase | output | 4 | Stepper phase lines |
| motor_on | output | 1 | Motor enable from the retriggerable timer |
| drv_en_n | output | 4 | Drive enables, active low, at most one low |
| load_sel | output | 1 | Shift/load mode bit for the data path |
| write_sel | output | 1 | Read/write mode bit for the data path |

## Verification
The assertions assume that the strobes and address are synchronous to `clk` and stable across each edge, so that one low cycle counts as one access. They also assume that reset lasts at least one edge. The bench meets both by changing every input only on the falling edge and by holding each strobe low for a single full cycle. The motor-window property counts idle cycles in the checker rather than using a long delay, so it holds for any `MOTOR_HOLD`. The bench shortens `MOTOR_HOLD` to a dozen cycles so that expiry and retrigger can both be reached.

// File: rtl/qdc_pkg.sv
// Package: shared constants for the four-drive control switches.
// Assumes a four-bit address window and a latch of eight single-bit switches.
package qdc_pkg;
    localparam int ADDR_W    = 4;
    localparam int LATCH_N   = 1 << (ADDR_W - 1);
    localparam int IDX_W     = ADDR_W - 1;
    localparam int PHASES    = 4;
    localparam int DRIVES    = 4;
    localparam int DSEL_W    = $clog2(DRIVES);
    // Latch positions whose meaning the outside logic decodes.
    localparam int SW_PHASE0 = 0;
    localparam int SW_SPARE  = 4;
    localparam int SW_UNIT   = 5;
    localparam int SW_LOAD   = 6;
    localparam int SW_WRITE  = 7;
endpackage

// File: rtl/qdc_strobe_pair.sv
// Merges the two active-low slot strobes into one access pulse and
// remembers which strobe was used last (the drive pair).
// Assumes both strobes are synchronous to clk. The auxiliary strobe wins a tie.
module qdc_strobe_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_main_n,
    input  logic sel_aux_n,
    output logic access,
    output logic pair_hi
);
    // Either strobe low counts as an access.
    assign access = !sel_main_n || !sel_aux_n;

    // Pair flip-flop: set by an auxiliary access, cleared by a primary-only access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_hi <= 1'b0;
        end else if (!sel_aux_n) begin
            pair_hi <= 1'b1;
        end else if (!sel_main_n) begin
            pair_hi <= 1'b0;
        end
    end
endmodule

// File: rtl/qdc_switch_latch.sv
// Addressable latch of single-bit soft switches: on a write the bit at
// wr_index takes wr_value, and the others hold.
// Positions cleared in LIVE_MASK carry no storage and read as 0.
module qdc_switch_latch #(
    parameter int          N         = 8,
    parameter int          IW        = 3,
    parameter logic [N-1:0] LIVE_MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_index,
    input  logic          wr_value,
    output logic [N-1:0]  q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (LIVE_MASK[i]) begin : g_live
            // One switch: load the written value when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q[i] <= 1'b0;
                end else if (wr_en && (wr_index == IW'(i))) begin
                    q[i] <= wr_value;
                end
            end
        end else begin : g_dead
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/qdc_motor_timer.sv
// Retriggerable one-shot: each kick reloads HOLD, and the output is high
// while the count is non-zero, which is HOLD cycles after the last kick.
// Assumes HOLD >= 1.
module qdc_motor_timer #(
    parameter int HOLD = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic running
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] remain;

    // Reload on a kick and count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (kick) begin
            remain <= CW'(HOLD);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Motor runs while time remains.
    assign running = (remain != '0);
endmodule

// File: rtl/qdc_drive_decode.sv
// One-of-N active-low decoder for the drive enables, with all outputs
// high while the motor is stopped.
module qdc_drive_decode #(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic          motor_on,
    input  logic [SW-1:0] unit_index,
    output logic [N-1:0]  en_n
);
    for (genvar d = 0; d < N; d++) begin : g_en
        // An enable goes low only for the indexed drive while the motor runs.
        assign en_n[d] = !(motor_on && (unit_index == SW'(d)));
    end
endmodule

// File: rtl/quad_drive_ctl.sv
// Control switches for a four-drive floppy card: the strobes are merged,
// the soft-switch latch is written, the pair is tracked, the drives are
// decoded and the motor timer is run.
// Assumes the strobes and address are synchronous to clk. MOTOR_HOLD is in clock cycles.
module quad_drive_ctl #(
    parameter int MOTOR_HOLD = 1_000_000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sel_main_n,
    input  logic                           sel_aux_n,
    input  logic [qdc_pkg::ADDR_W-1:0]     addr,
    output logic [qdc_pkg::PHASES-1:0]     step_phase,
    output logic                           motor_on,
    output logic [qdc_pkg::DRIVES-1:0]     drv_en_n,
    output logic                           load_sel,
    output logic                           write_sel
);
    import qdc_pkg::*;

    localparam logic [LATCH_N-1:0] LIVE = ~(LATCH_N'(1) << SW_SPARE);

    logic               access;
    logic               pair_hi;
    logic [LATCH_N-1:0] sw;
    logic               spare_unused;

    qdc_strobe_pair u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_main_n (sel_main_n),
        .sel_aux_n  (sel_aux_n),
        .access     (access),
        .pair_hi    (pair_hi)
    );

    qdc_switch_latch #(
        .N         (LATCH_N),
        .IW        (IDX_W),
        .LIVE_MASK (LIVE)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (access),
        .wr_index (addr[ADDR_W-1:1]),
        .wr_value (addr[0]),
        .q        (sw)
    );

    qdc_motor_timer #(
        .HOLD (MOTOR_HOLD)
    ) u_motor (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (access),
        .running (motor_on)
    );

    qdc_drive_decode #(
        .N  (DRIVES),
        .SW (DSEL_W)
    ) u_decode (
        .motor_on   (motor_on),
        .unit_index ({pair_hi, sw[SW_UNIT]}),
        .en_n       (drv_en_n)
    );

    // Route the latch positions to their pins.
    assign step_phase   = sw[SW_PHASE0 +: PHASES];
    assign load_sel     = sw[SW_LOAD];
    assign write_sel    = sw[SW_WRITE];
    assign spare_unused = sw[SW_SPARE];
endmodule

// File: rtl/quad_drive_ctl_chk.sv
// Checker for quad_drive_ctl. It watches only the ports and keeps its
// own idle counter to check the motor window.
module quad_drive_ctl_chk #(
    parameter int MOTOR_HOLD = 1_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_main_n,
    input logic       sel_aux_n,
    input logic [3:0] addr,
    input logic [3:0] step_phase,
    input logic       motor_on,
    input logic [3:0] drv_en_n,
    input logic       load_sel,
    input logic       write_sel
);
    localparam int CW = $clog2(MOTOR_HOLD + 1);

    logic          acc;
    logic [CW-1:0] idle;

    assign acc = !sel_main_n || !sel_aux_n;

    // Cycles since the last access, saturating at MOTOR_HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle <= CW'(MOTOR_HOLD);
        end else if (acc) begin
            idle <= '0;
        end else if (idle != CW'(MOTOR_HOLD)) begin
            idle <= idle + 1'b1;
        end
    end

    p_phase_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !addr[3]) |=> step_phase[$past(addr[2:1])] == $past(addr[0]));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(step_phase) && $stable(load_sel) && $stable(write_sel)));

    p_aux_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_aux_n |=> (drv_en_n[1:0] == 2'b11) && (drv_en_n[3:2] != 2'b11));

    p_main_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_main_n && sel_aux_n) |=> (drv_en_n[3:2] == 2'b11) && (drv_en_n[1:0] != 2'b11));

    p_one_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~drv_en_n));

    p_motor_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        motor_on == (idle < CW'(MOTOR_HOLD)));

    p_stopped_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !motor_on |-> (drv_en_n == 4'b1111));
endmodule

bind quad_drive_ctl quad_drive_ctl_chk #(.MOTOR_HOLD(MOTOR_HOLD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_main_n (sel_main_n),
    .sel_aux_n  (sel_aux_n),
    .addr       (addr),
    .step_phase (step_phase),
    .motor_on   (motor_on),
    .drv_en_n   (drv_en_n),
    .load_sel   (load_sel),
    .write_sel  (write_sel)
);

// File: tb/quad_drive_ctl_test.sv
// Bench for quad_drive_ctl: a vector table walked by one loop, then
// directed tests of motor expiry, retrigger and reset.
module quad_drive_ctl_test;
    localparam int HOLD = 12;
    localparam int NV   = 14;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_main_n, sel_aux_n;
    logic [3:0] addr;
    logic [3:0] step_phase, drv_en_n;
    logic       motor_on, load_sel, write_sel;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    quad_drive_ctl #(.MOTOR_HOLD(HOLD)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_main_n (sel_main_n),
        .sel_aux_n  (sel_aux_n),
        .addr       (addr),
        .step_phase (step_phase),
        .motor_on   (motor_on),
        .drv_en_n   (drv_en_n),
        .load_sel   (load_sel),
        .write_sel  (write_sel)
    );

    // Vector: {main_n, aux_n, addr[3:0], phase[3:0], load, write, en_n[3:0]}
    localparam logic [15:0] VEC [NV] = '{
        {2'b01, 4'b0001, 4'b0001, 2'b00, 4'b1110},  // R3 phase0 set, lower pair
        {2'b01, 4'b0011, 4'b0011, 2'b00, 4'b1110},  // R3 phase1 set
        {2'b10, 4'b1011, 4'b0011, 2'b00, 4'b0111},  // R4 R6 aux, second unit
        {2'b10, 4'b0000, 4'b0010, 2'b00, 4'b0111},  // R1 aux writes phase0 clear
        {2'b01, 4'b1010, 4'b0010, 2'b00, 4'b1110},  // R6 main clears pair
        {2'b01, 4'b1011, 4'b0010, 2'b00, 4'b1101},  // R4 unit 1 lower pair
        {2'b10, 4'b1101, 4'b0010, 2'b10, 4'b0111},  // R5 load set
        {2'b10, 4'b1010, 4'b0010, 2'b10, 4'b1011},  // R7 drive 2
        {2'b00, 4'b1111, 4'b0010, 2'b11, 4'b1011},  // R6 both low: aux wins, R5 write
        {2'b01, 4'b0101, 4'b0110, 2'b11, 4'b1110},  // R2 phase2
        {2'b01, 4'b0111, 4'b1110, 2'b11, 4'b1110},  // R2 phase3
        {2'b11, 4'b0000, 4'b1110, 2'b11, 4'b1110},  // R11 no access ignored
        {2'b10, 4'b1100, 4'b1110, 2'b01, 4'b1011},  // R5 load clear
        {2'b01, 4'b1110, 4'b1110, 2'b00, 4'b1110}   // R5 write clear
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic mn, input logic an, input logic [3:0] a);
        sel_main_n = mn;
        sel_aux_n  = an;
        addr       = a;
        @(posedge clk);
        @(negedge clk);
        sel_main_n = 1'b1;
        sel_aux_n  = 1'b1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; sel_main_n = 1'b1; sel_aux_n = 1'b1; addr = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 phases", 8'(step_phase), 8'h0);
        check("R10 enables", 8'(drv_en_n), 8'hF);
        check("R10 motor", 8'(motor_on), 8'h0);
        check("R10 modes", 8'({load_sel, write_sel}), 8'h0);

        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][15], VEC[i][14], VEC[i][13:10]);
            check($sformatf("R2 vec%0d phase", i), 8'(step_phase), 8'(VEC[i][9:6]));
            check($sformatf("R5 vec%0d modes", i), 8'({load_sel, write_sel}), 8'(VEC[i][5:4]));
            check($sformatf("R7 vec%0d enables", i), 8'(drv_en_n), 8'(VEC[i][3:0]));
        end

        // R8 motor window: on for HOLD samples, then off; R9 enables drop.
        pulse(1'b0, 1'b1, 4'b1010);
        for (int j = 0; j < HOLD; j++) begin
            check($sformatf("R8 on j=%0d", j), 8'(motor_on), 8'h1);
            @(negedge clk);
        end
        check("R8 expired", 8'(motor_on), 8'h0);
        check("R9 enables idle", 8'(drv_en_n), 8'hF);

        // R8 retrigger mid-window restarts the full count.
        pulse(1'b1, 1'b0, 4'b1011);
        repeat (HOLD - 3) @(negedge clk);
        pulse(1'b1, 1'b0, 4'b1011);
        repeat (HOLD - 1) @(negedge clk);
        check("R8 retrigger still on", 8'(motor_on), 8'h1);
        check("R7 upper second", 8'(drv_en_n), 8'b0111);
        @(negedge clk);
        check("R8 retrigger off", 8'(motor_on), 8'h0);

        // R11 idle address changes with the motor stopped: no effect.
        addr = 4'b0001;
        repeat (3) @(negedge clk);
        check("R11 idle phases", 8'(step_phase), 8'b1110);
        check("R11 idle motor", 8'(motor_on), 8'h0);

        // R10 reset mid-operation.
        pulse(1'b1, 1'b0, 4'b1101);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 mid phases", 8'(step_phase), 8'h0);
        check("R10 mid modes", 8'({load_sel, write_sel}), 8'h0);
        check("R10 mid motor", 8'(motor_on), 8'h0);
        pulse(1'b0, 1'b0, 4'b0000);
        check("R1 both strobes upper", 8'(drv_en_n), 8'b1011);
        pulse(1'b0, 1'b1, 4'b0000);
        check("R10 pair after main", 8'(drv_en_n), 8'b1110);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule